// File: doc/BRIEF.md
# Scalar Half-Precision Fused Multiply-Add

This unit computes one fused multiply-add on 16-bit IEEE half-precision numbers. Three 128-bit vector operands arrive: a destination that is also the first source, a second source and a third source. Only their low 16-bit lanes take part in the arithmetic. An order select decides which lanes feed the two multiplier inputs and which one is the addend. A negate flag flips the sign of the exact product before the addend is added. The sum is rounded once, using the rounding mode chosen for that operation.

The low lane of the 128-bit result carries the rounded value, subject to a one-bit write mask. When the mask is in force and clear, the low lane is either cleared or keeps the destination's old lane. The upper lanes always pass through from the destination. Any output bits above the 128-bit vector are driven to zero. Five exception flags go with each result, and each result appears one clock after its valid input.

Top module: `fma16_scalar_unit`

## Requirements
- R1: order_sel picks the operands (A, B, C) of ±A·B+C. 0 uses (dst, src3, src2), 1 uses (src2, dst, src3), and 2 or any other code uses (src2, src3, dst).
- R2: With negate high, the exact product A·B changes sign before C is added, and there is exactly one rounding of the final sum.
- R3: The rounding mode is rnd_inline when rnd_override and src3_is_reg are both high, and rnd_global otherwise. The encoding is 00 nearest-even, 01 toward −∞, 10 toward +∞, 11 toward zero.
- R4: Finite results, subnormal ones included, equal the exact ±A·B+C rounded once in the selected mode. exc_flags bit 4 (inexact) is set when the rounding changed the value. Flag positions: bit 0 invalid, bit 1 denormal operand, bit 2 overflow, bit 3 underflow, bit 4 inexact.
- R5: When the rounded magnitude exceeds the largest finite value, overflow and inexact are set. The result is then infinity or ±0x7BFF, whichever the mode and sign direct.
- R6: Underflow is set when the exact nonzero result lies below 2^-14 and is also inexact.
- R7: Any NaN operand gives 0x7E00. A signaling NaN operand, infinity times zero, or the sum of opposite-signed infinities sets invalid. Infinity times zero and the sum of opposite-signed infinities also give 0x7E00.
- R8: An exact zero sum of terms with opposite signs is +0 in every mode except toward −∞, which gives −0. A sum of two zeros with the same sign keeps that sign.
- R9: The denormal flag is set when any of A, B, C is subnormal and none of them is a NaN.
- R10: The low lane is written when mask_en is low or mask_bit is high. Otherwise it is 0 when zero_mask is high, or the destination's old low lane when zero_mask is low. In both of those cases all flags are 0.
- R11: result[127:16] equals dst_vec[127:16] of the same operation, and result bits above 127 are 0.
- R12: out_valid is high exactly one cycle after each cycle with in_valid high. result and exc_flags hold when in_valid is low, and all outputs reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| dst_vec | input | 128 | Destination / first source vector |
| src2_vec | input | 128 | Second source vector |
| src3_vec | input | 128 | Third source vector |
| order_sel | input | 3 | Operand order select |
| negate | input | 1 | Negate the product |
| mask_en | input | 1 | Write masking in force |
| mask_bit | input | 1 | Mask bit for the low lane |
| zero_mask | input | 1 | 1: clear a masked lane, 0: merge |
| rnd_override | input | 1 | Per-operation rounding request |
| src3_is_reg | input | 1 | Third source is a register |
| rnd_inline | input | 2 | Per-operation rounding mode |
| rnd_global | input | 2 | Global rounding mode |
| out_valid | output | 1 | Result valid |
| result | output | 256 | Result vector (bits above 127 zero) |
| exc_flags | output | 5 | {inexact, underflow, overflow, denormal, invalid} |

## Verification
Masking and exception detection act in the same cycle. An operand can raise invalid, overflow or underflow on exactly the operation whose low lane the mask suppresses. The bench provokes this by driving signaling NaNs, overflowing products and tiny subnormal products with mask_en high and mask_bit low, in both zero and merge modes, back-to-back with unmasked operations. It expects all flags clear and the lane cleared or merged. Rounding-mode selection and overflow also meet in one operation. Overflowing products are issued with the override pair set in each combination, and the result must saturate or become infinite as the chosen mode directs.

// File: rtl/fma16_pkg.sv
package fma16_pkg;
  localparam int HW     = 16;
  localparam int EXP_W  = 5;
  localparam int FRAC_W = 10;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  // fixed point with LSB 2^-48 covers every product and addend exactly
  localparam int ACC_W  = 84;
  localparam int LZ_W   = 7;
  localparam int SUB_SH = 24;           // shift that puts the LSB at 2^-24
  localparam int NORM_L = SUB_SH + FRAC_W; // lowest leading-one index of a normal
  localparam logic [HW-1:0] QNAN = 16'h7E00;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_DOWN      = 2'b01,
    RM_UP        = 2'b10,
    RM_ZERO      = 2'b11
  } rmode_e;

  typedef struct packed {
    logic inexact;
    logic underflow;
    logic overflow;
    logic denormal;
    logic invalid;
  } fflags_t;

  function automatic logic f_nan(input logic [HW-1:0] v);
    return (v[14:10] == 5'h1F) && (v[9:0] != '0);
  endfunction

  function automatic logic f_snan(input logic [HW-1:0] v);
    return f_nan(v) && !v[9];
  endfunction

  function automatic logic f_inf(input logic [HW-1:0] v);
    return (v[14:10] == 5'h1F) && (v[9:0] == '0);
  endfunction

  function automatic logic f_zero(input logic [HW-1:0] v);
    return v[14:0] == '0;
  endfunction

  function automatic logic f_sub(input logic [HW-1:0] v);
    return (v[14:10] == '0) && (v[9:0] != '0);
  endfunction

  function automatic logic [SIG_W-1:0] f_sig(input logic [HW-1:0] v);
    return {v[14:10] != '0, v[9:0]};
  endfunction

  function automatic logic [EXP_W-1:0] f_eexp(input logic [HW-1:0] v);
    return (v[14:10] == '0) ? 5'd1 : v[14:10];
  endfunction

  function automatic logic [LZ_W-1:0] lead_one(input logic [ACC_W-1:0] v);
    logic [LZ_W-1:0] pos;
    pos = '0;
    for (int i = 0; i < ACC_W; i++) if (v[i]) pos = LZ_W'(i);
    return pos;
  endfunction

  function automatic logic round_inc(input rmode_e rm, input logic sgn,
                                     input logic lsb, input logic rb, input logic sb);
    case (rm)
      RM_NEAR_EVEN: return rb && (sb || lsb);
      RM_DOWN:      return (rb || sb) && sgn;
      RM_UP:        return (rb || sb) && !sgn;
      default:      return 1'b0;
    endcase
  endfunction

  function automatic logic [HW-1:0] ovf_value(input rmode_e rm, input logic sgn);
    logic to_inf;
    case (rm)
      RM_NEAR_EVEN: to_inf = 1'b1;
      RM_DOWN:      to_inf = sgn;
      RM_UP:        to_inf = !sgn;
      default:      to_inf = 1'b0;
    endcase
    return {sgn, to_inf ? 15'h7C00 : 15'h7BFF};
  endfunction
endpackage

// File: rtl/fma16_operand_route.sv
module fma16_operand_route
  import fma16_pkg::*;
(
  input  logic [HW-1:0] dst_lo,
  input  logic [HW-1:0] s2_lo,
  input  logic [HW-1:0] s3_lo,
  input  logic [2:0]    order_sel,
  output logic [HW-1:0] mul_a,
  output logic [HW-1:0] mul_b,
  output logic [HW-1:0] addend
);
  always_comb begin
    case (order_sel)
      3'd0: begin mul_a = dst_lo; mul_b = s3_lo;  addend = s2_lo;  end
      3'd1: begin mul_a = s2_lo;  mul_b = dst_lo; addend = s3_lo;  end
      default: begin mul_a = s2_lo; mul_b = s3_lo; addend = dst_lo; end
    endcase
  end
endmodule

// File: rtl/fma16_datapath.sv
module fma16_datapath
  import fma16_pkg::*;
(
  input  logic [HW-1:0] op_a,
  input  logic [HW-1:0] op_b,
  input  logic [HW-1:0] op_c,
  input  logic          neg_prod,
  input  rmode_e        rm,
  output logic [HW-1:0] res,
  output fflags_t       flg,
  output logic          special_evt,
  output logic          tiny_evt
);
  logic              any_nan, any_snan, inf_zero, prod_inf, sp, sc, rsign;
  logic [LZ_W-1:0]   pshift, cshift, lead, shamt;
  logic [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  pmag, cmag, mag, half;
  logic [11:0]       kept;
  logic              rbit, sbit, inc;
  logic [16:0]       enc;

  assign any_nan  = f_nan(op_a) || f_nan(op_b) || f_nan(op_c);
  assign any_snan = f_snan(op_a) || f_snan(op_b) || f_snan(op_c);
  assign inf_zero = (f_inf(op_a) && f_zero(op_b)) || (f_zero(op_a) && f_inf(op_b));
  assign prod_inf = (f_inf(op_a) || f_inf(op_b)) && !inf_zero;
  assign sp       = op_a[15] ^ op_b[15] ^ neg_prod;
  assign sc       = op_c[15];

  // exact sum on a fixed-point grid, LSB = 2^-48
  always_comb begin
    prod   = {{SIG_W{1'b0}}, f_sig(op_a)} * {{SIG_W{1'b0}}, f_sig(op_b)};
    pshift = {2'b0, f_eexp(op_a)} + {2'b0, f_eexp(op_b)} - 7'd2;
    cshift = {2'b0, f_eexp(op_c)} + 7'd23;
    pmag   = ACC_W'(prod) << pshift;
    cmag   = ACC_W'(f_sig(op_c)) << cshift;
    if (sp == sc) begin
      mag = pmag + cmag; rsign = sp;
    end else if (pmag >= cmag) begin
      mag = pmag - cmag; rsign = sp;
    end else begin
      mag = cmag - pmag; rsign = sc;
    end
  end

  // single rounding: keep up to 11 significant bits, LSB never below 2^-24
  always_comb begin
    lead  = lead_one(mag);
    shamt = (lead >= 7'(NORM_L)) ? lead - 7'(FRAC_W) : 7'(SUB_SH);
    kept  = 12'(mag >> shamt);
    half  = ACC_W'(1) << (shamt - 7'd1);
    rbit  = |(mag & half);
    sbit  = |(mag & (half - ACC_W'(1)));
    inc   = round_inc(rm, rsign, kept[0], rbit, sbit);
    // exponent field and hidden bit add up, so a rounding carry lifts the exponent
    enc   = {shamt - 7'(SUB_SH), 10'd0} + {5'd0, kept} + 17'(inc);
  end

  assign tiny_evt    = (mag != '0) && (lead < 7'(NORM_L));
  assign special_evt = any_nan || inf_zero || prod_inf || f_inf(op_c);

  always_comb begin
    flg          = '0;
    flg.denormal = (f_sub(op_a) || f_sub(op_b) || f_sub(op_c)) && !any_nan;
    if (any_nan || inf_zero) begin
      res = QNAN; flg.invalid = any_snan || inf_zero;
    end else if (prod_inf && f_inf(op_c) && (sp != sc)) begin
      res = QNAN; flg.invalid = 1'b1;
    end else if (prod_inf) begin
      res = {sp, 15'h7C00};
    end else if (f_inf(op_c)) begin
      res = {sc, 15'h7C00};
    end else if (mag == '0) begin
      res = {(sp == sc) ? sp : (rm == RM_DOWN), 15'h0000};
    end else if (enc >= 17'h07C00) begin
      res = ovf_value(rm, rsign);
      flg.overflow = 1'b1;
      flg.inexact  = 1'b1;
    end else begin
      res = {rsign, enc[14:0]};
      flg.inexact   = rbit || sbit;
      flg.underflow = tiny_evt && (rbit || sbit);
    end
  end
endmodule

// File: rtl/fma16_lane_merge.sv
module fma16_lane_merge
  import fma16_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int OUT_W = 256
) (
  input  logic [VEC_W-1:0] dst_vec,
  input  logic [HW-1:0]    fma_val,
  input  fflags_t          fma_flg,
  input  logic             lane_wr,
  input  logic             zero_mask,
  output logic [OUT_W-1:0] vec_out,
  output fflags_t          flg_out
);
  localparam int PAD_W = OUT_W - VEC_W;
  logic [HW-1:0] lane;

  assign lane    = lane_wr ? fma_val : (zero_mask ? '0 : dst_vec[HW-1:0]);
  assign flg_out = lane_wr ? fma_flg : '0;

  generate
    if (PAD_W > 0) begin : g_pad
      assign vec_out = {{PAD_W{1'b0}}, dst_vec[VEC_W-1:HW], lane};
    end else begin : g_nopad
      assign vec_out = {dst_vec[VEC_W-1:HW], lane};
    end
  endgenerate
endmodule

// File: rtl/fma16_scalar_unit.sv
module fma16_scalar_unit
  import fma16_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int OUT_W = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] dst_vec,
  input  logic [VEC_W-1:0] src2_vec,
  input  logic [VEC_W-1:0] src3_vec,
  input  logic [2:0]       order_sel,
  input  logic             negate,
  input  logic             mask_en,
  input  logic             mask_bit,
  input  logic             zero_mask,
  input  logic             rnd_override,
  input  logic             src3_is_reg,
  input  logic [1:0]       rnd_inline,
  input  logic [1:0]       rnd_global,
  output logic             out_valid,
  output logic [OUT_W-1:0] result,
  output logic [4:0]       exc_flags
);
  logic [HW-1:0]    mul_a, mul_b, addend, fma_res;
  fflags_t          fma_flg, lane_flg;
  logic             special_evt, tiny_evt, lane_wr;
  rmode_e           rm_eff;
  logic [OUT_W-1:0] vec_n;
  logic             unused_hi;

  assign unused_hi = ^{src2_vec[VEC_W-1:HW], src3_vec[VEC_W-1:HW], special_evt};
  assign rm_eff    = rmode_e'((rnd_override && src3_is_reg) ? rnd_inline : rnd_global);
  assign lane_wr   = !mask_en || mask_bit;

  fma16_operand_route u_route (
    .dst_lo(dst_vec[HW-1:0]), .s2_lo(src2_vec[HW-1:0]), .s3_lo(src3_vec[HW-1:0]),
    .order_sel(order_sel), .mul_a(mul_a), .mul_b(mul_b), .addend(addend)
  );

  fma16_datapath u_dp (
    .op_a(mul_a), .op_b(mul_b), .op_c(addend), .neg_prod(negate), .rm(rm_eff),
    .res(fma_res), .flg(fma_flg), .special_evt(special_evt), .tiny_evt(tiny_evt)
  );

  fma16_lane_merge #(.VEC_W(VEC_W), .OUT_W(OUT_W)) u_merge (
    .dst_vec(dst_vec), .fma_val(fma_res), .fma_flg(fma_flg), .lane_wr(lane_wr),
    .zero_mask(zero_mask), .vec_out(vec_n), .flg_out(lane_flg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      exc_flags <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= vec_n;
        exc_flags <= lane_flg;
      end
    end
  end

  // R12: one-cycle latency and holding
  p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(exc_flags)));
  // R11: upper lanes follow the destination
  p_upper_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> result[VEC_W-1:HW] == $past(dst_vec[VEC_W-1:HW]));
  // R10: masked lane is quiet and cleared or merged
  p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !lane_wr) |=> exc_flags == 5'd0);
  p_zero_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !lane_wr && zero_mask) |=> result[HW-1:0] == '0);
  p_merge_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !lane_wr && !zero_mask) |=> result[HW-1:0] == $past(dst_vec[HW-1:0]));
  // R7: the arithmetic only ever produces the canonical NaN
  p_canon_nan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fma_res[14:10] == 5'h1F && fma_res[9:0] != '0) |-> fma_res == QNAN);
  // R5: overflow always comes with inexact
  p_ovf_inexact_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fma_flg.overflow) |-> fma_flg.inexact);
  // R6: underflow needs a tiny, inexact result
  p_unf_tiny_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fma_flg.underflow) |-> (fma_flg.inexact && tiny_evt));
endmodule

// File: tb/tb_fma16_scalar_unit.sv
`timescale 1ns/1ps
module tb_fma16_scalar_unit;
  localparam int OUT_W = 256;
  localparam int EXP_W = OUT_W + 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, in_valid, negate, mask_en, mask_bit, zero_mask, rnd_override, src3_is_reg;
  logic [127:0] dst_vec, src2_vec, src3_vec;
  logic [2:0] order_sel;
  logic [1:0] rnd_inline, rnd_global;
  logic out_valid;
  logic [OUT_W-1:0] result;
  logic [4:0] exc_flags;

  fma16_scalar_unit #(.VEC_W(128), .OUT_W(OUT_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dst_vec(dst_vec), .src2_vec(src2_vec),
    .src3_vec(src3_vec), .order_sel(order_sel), .negate(negate), .mask_en(mask_en),
    .mask_bit(mask_bit), .zero_mask(zero_mask), .rnd_override(rnd_override),
    .src3_is_reg(src3_is_reg), .rnd_inline(rnd_inline), .rnd_global(rnd_global),
    .out_valid(out_valid), .result(result), .exc_flags(exc_flags)
  );

  logic [EXP_W-1:0] exp_q[$];
  string            tag_q[$];
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // reference: exact value on a 2^-48 grid, rounded by quotient and remainder
  function automatic logic [20:0] ref_fma(input logic [15:0] a, b, c,
                                          input logic ng, input logic [1:0] rm);
    logic an, bn, cn, asn, bsn, csn, ai, bi, ci, az, bz, cz, den, sp, sc, rs, up, found, ovf;
    logic signed [127:0] pv, cv, tot;
    logic [127:0] mag, q, r, half, ma, mb, mc;
    logic [4:0] fl;
    logic [15:0] res;
    int ka, kb, kc, e, s;
    an = (a[14:10] == 5'h1F) && (a[9:0] != 0); asn = an && !a[9];
    bn = (b[14:10] == 5'h1F) && (b[9:0] != 0); bsn = bn && !b[9];
    cn = (c[14:10] == 5'h1F) && (c[9:0] != 0); csn = cn && !c[9];
    ai = (a[14:0] == 15'h7C00); bi = (b[14:0] == 15'h7C00); ci = (c[14:0] == 15'h7C00);
    az = (a[14:0] == 0); bz = (b[14:0] == 0); cz = (c[14:0] == 0);
    den = ((a[14:10] == 0 && !az) || (b[14:10] == 0 && !bz) || (c[14:10] == 0 && !cz))
          && !(an || bn || cn);
    sp = a[15] ^ b[15] ^ ng; sc = c[15];
    fl = {4'b0000, 1'b0}; fl[1] = den;
    if (an || bn || cn || (ai && bz) || (az && bi)) begin
      fl[0] = asn || bsn || csn || (ai && bz) || (az && bi);
      return {fl, 16'h7E00};
    end
    if ((ai || bi) && ci) begin
      if (sp != sc) begin fl[0] = 1'b1; return {fl, 16'h7E00}; end
      return {fl, sp, 15'h7C00};
    end
    if (ai || bi) return {fl, sp, 15'h7C00};
    if (ci) return {fl, sc, 15'h7C00};
    ka = ((a[14:10] == 0) ? 1 : int'(a[14:10])) - 25;
    kb = ((b[14:10] == 0) ? 1 : int'(b[14:10])) - 25;
    kc = ((c[14:10] == 0) ? 1 : int'(c[14:10])) - 25;
    ma = {117'd0, a[14:10] != 0, a[9:0]};
    mb = {117'd0, b[14:10] != 0, b[9:0]};
    mc = {117'd0, c[14:10] != 0, c[9:0]};
    pv = $signed((ma * mb) << (ka + kb + 48));
    cv = $signed(mc << (kc + 48));
    tot = (sp ? -pv : pv) + (sc ? -cv : cv);
    if (tot == 0) return {fl, ((sp == sc) ? sp : (rm == 2'b01)), 15'h0000};
    rs = tot < 0;
    mag = rs ? 128'(-tot) : 128'(tot);
    ovf = mag >= (128'd1 << 64);
    found = 0; e = -14;
    for (int t = 15; t >= -14; t--)
      if (!found && mag >= (128'd1 << (t + 48))) begin e = t; found = 1; end
    s = e + 38;
    q = mag >> s;
    r = mag - (q << s);
    half = 128'd1 << (s - 1);
    case (rm)
      2'b00: up = (r > half) || (r == half && q[0]);
      2'b01: up = (r != 0) && rs;
      2'b10: up = (r != 0) && !rs;
      default: up = 1'b0;
    endcase
    q = q + 128'(up);
    if (q == 128'd2048) begin q = 128'd1024; e = e + 1; end
    if (e > 15) ovf = 1'b1;
    if (ovf) begin
      fl[2] = 1'b1; fl[4] = 1'b1;
      case (rm)
        2'b00: res = {rs, 15'h7C00};
        2'b01: res = {rs, rs ? 15'h7C00 : 15'h7BFF};
        2'b10: res = {rs, rs ? 15'h7BFF : 15'h7C00};
        default: res = {rs, 15'h7BFF};
      endcase
      return {fl, res};
    end
    fl[4] = (r != 0);
    fl[3] = (r != 0) && (mag < (128'd1 << 34));
    if (q < 128'd1024) res = {rs, 5'd0, q[9:0]};
    else res = {rs, 5'(e + 15), q[9:0]};
    return {fl, res};
  endfunction

  task automatic push_op(input logic [127:0] d, s2, s3, input logic [2:0] ord,
                         input logic ng, me, mb, zm, ov, sr, input logic [1:0] emb, gl,
                         input bit lit, input logic [15:0] lres, input logic [4:0] lflg,
                         input string tag);
    logic [15:0] a, b, c, lane;
    logic [1:0] rm;
    logic [20:0] m;
    logic [4:0] fl;
    rm = (ov && sr) ? emb : gl;                       // R3
    case (ord)                                        // R1
      3'd0: begin a = d[15:0];  b = s3[15:0]; c = s2[15:0]; end
      3'd1: begin a = s2[15:0]; b = d[15:0];  c = s3[15:0]; end
      default: begin a = s2[15:0]; b = s3[15:0]; c = d[15:0]; end
    endcase
    m = ref_fma(a, b, c, ng, rm);
    if (lit) begin lane = lres; fl = lflg; end
    else if (!me || mb) begin lane = m[15:0]; fl = m[20:16]; end
    else begin lane = zm ? 16'h0 : d[15:0]; fl = 5'd0; end  // R10
    @(negedge clk);
    dst_vec = d; src2_vec = s2; src3_vec = s3; order_sel = ord; negate = ng;
    mask_en = me; mask_bit = mb; zero_mask = zm; rnd_override = ov; src3_is_reg = sr;
    rnd_inline = emb; rnd_global = gl; in_valid = 1'b1;
    exp_q.push_back({fl, {(OUT_W-128){1'b0}}, d[127:16], lane});
    tag_q.push_back(tag);
  endtask

  task automatic op(input logic [127:0] d, s2, s3, input logic [2:0] ord, input logic ng,
                    input logic [1:0] gl, input string tag);
    push_op(d, s2, s3, ord, ng, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, gl, 1'b0, 16'h0, 5'h0, tag);
  endtask

  task automatic lit_op(input logic [15:0] d, s2, s3, input logic [2:0] ord, input logic ng,
                        input logic [1:0] gl, input logic [15:0] er, input logic [4:0] ef,
                        input string tag);
    push_op({112'h1234_5678_9ABC_DEF0_0F1E_2D3C_4B5A, d}, {112'h0, s2}, {112'h0, s3}, ord, ng,
            1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, gl, 1'b1, er, ef, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); in_valid = 1'b0; end
  endtask

  function automatic logic [15:0] rnd_half();
    logic [15:0] pick[8];
    pick = '{16'h0000, 16'h8000, 16'h7C00, 16'hFC00, 16'h7D01, 16'h7E00, 16'h0001, 16'h83FF};
    if ($urandom_range(7) == 0) return pick[$urandom_range(7)];
    if ($urandom_range(3) == 0) return {$urandom_range(1) == 1, 5'($urandom_range(10, 20)), 10'($urandom)};
    return 16'($urandom);
  endfunction

  // monitor: compare each result with the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R12 unexpected out_valid: actual result=%h expected no output", result);
      end else begin
        logic [EXP_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({exc_flags, result} !== e) begin
          n_bad++;
          $display("FAIL %s: actual flags=%b lane=%h upper=%h expected flags=%b lane=%h upper=%h",
                   t, exc_flags, result[15:0], result[OUT_W-1:16],
                   e[EXP_W-1:OUT_W], e[15:0], e[OUT_W-1:16]);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL R12 watchdog expired: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [OUT_W-1:0] held;
    rst_n = 1'b0; in_valid = 1'b0; dst_vec = '0; src2_vec = '0; src3_vec = '0;
    order_sel = '0; negate = 0; mask_en = 0; mask_bit = 0; zero_mask = 0;
    rnd_override = 0; src3_is_reg = 0; rnd_inline = '0; rnd_global = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_cmp++;
    if (out_valid !== 1'b0 || result !== '0 || exc_flags !== 5'd0) begin
      n_bad++;
      $display("FAIL R12 reset state: actual v=%b r=%h f=%b expected 0/0/0", out_valid, result, exc_flags);
    end

    // R1: operand orders on dst=2.0, src2=3.0, src3=0.5
    lit_op(16'h4000, 16'h4200, 16'h3800, 3'd0, 0, 2'b00, 16'h4400, 5'd0, "R1 order 132");
    lit_op(16'h4000, 16'h4200, 16'h3800, 3'd1, 0, 2'b00, 16'h4680, 5'd0, "R1 order 213");
    lit_op(16'h4000, 16'h4200, 16'h3800, 3'd2, 0, 2'b00, 16'h4300, 5'd0, "R1 order 231");
    lit_op(16'h4000, 16'h4200, 16'h3800, 3'd5, 0, 2'b00, 16'h4300, 5'd0, "R1 other code");
    // R2: negated product
    lit_op(16'h4000, 16'h4200, 16'h3800, 3'd2, 1, 2'b00, 16'h3800, 5'd0, "R2 negate");
    // R8: exact cancellation sign
    lit_op(16'h3C00, 16'h3C00, 16'h3C00, 3'd2, 1, 2'b00, 16'h0000, 5'd0, "R8 zero nearest");
    lit_op(16'h3C00, 16'h3C00, 16'h3C00, 3'd2, 1, 2'b01, 16'h8000, 5'd0, "R8 zero down");
    lit_op(16'h8000, 16'h8000, 16'h3C00, 3'd2, 0, 2'b00, 16'h8000, 5'd0, "R8 -0 + -0");
    // R3/R4: 1 + 2^-11 tie
    lit_op(16'h1000, 16'h3C00, 16'h3C00, 3'd2, 0, 2'b00, 16'h3C00, 5'b10000, "R4 tie to even");
    lit_op(16'h1000, 16'h3C00, 16'h3C00, 3'd2, 0, 2'b10, 16'h3C01, 5'b10000, "R3 global up");
    push_op({112'h0, 16'h1000}, {112'h0, 16'h3C00}, {112'h0, 16'h3C00}, 3'd2, 0, 0, 0, 0,
            1, 1, 2'b10, 2'b00, 1'b1, 16'h3C01, 5'b10000, "R3 inline override");
    push_op({112'h0, 16'h1000}, {112'h0, 16'h3C00}, {112'h0, 16'h3C00}, 3'd2, 0, 0, 0, 0,
            1, 0, 2'b10, 2'b00, 1'b1, 16'h3C00, 5'b10000, "R3 override ignored, not reg");
    // R5: overflow by mode
    lit_op(16'h0000, 16'h7BFF, 16'h4000, 3'd2, 0, 2'b00, 16'h7C00, 5'b10100, "R5 ovf nearest");
    lit_op(16'h0000, 16'h7BFF, 16'h4000, 3'd2, 0, 2'b11, 16'h7BFF, 5'b10100, "R5 ovf zero");
    lit_op(16'h0000, 16'h7BFF, 16'h4000, 3'd2, 1, 2'b10, 16'hFBFF, 5'b10100, "R5 ovf neg up");
    lit_op(16'h0000, 16'h7BFF, 16'h4000, 3'd2, 1, 2'b01, 16'hFC00, 5'b10100, "R5 ovf neg down");
    // R6/R9: subnormal operands
    lit_op(16'h0000, 16'h0001, 16'h3800, 3'd2, 0, 2'b00, 16'h0000, 5'b11010, "R6 tiny tie");
    lit_op(16'h0000, 16'h0001, 16'h3800, 3'd2, 0, 2'b10, 16'h0001, 5'b11010, "R6 tiny up");
    lit_op(16'h0000, 16'h0002, 16'h3800, 3'd2, 0, 2'b00, 16'h0001, 5'b00010, "R9 exact subnormal");
    // R7: special values
    lit_op(16'h3C00, 16'h7D00, 16'h3C00, 3'd2, 0, 2'b00, 16'h7E00, 5'b00001, "R7 signaling NaN");
    lit_op(16'h7E55, 16'h3C00, 16'h3C00, 3'd2, 0, 2'b00, 16'h7E00, 5'b00000, "R7 quiet NaN");
    lit_op(16'h3C00, 16'h7C00, 16'h0000, 3'd2, 0, 2'b00, 16'h7E00, 5'b00001, "R7 inf times zero");
    lit_op(16'hFC00, 16'h7C00, 16'h3C00, 3'd2, 0, 2'b00, 16'h7E00, 5'b00001, "R7 inf minus inf");
    lit_op(16'h3C00, 16'h7C00, 16'h3C00, 3'd2, 1, 2'b00, 16'hFC00, 5'b00000, "R7 negated inf");
    // R10: masked lanes next to flag-raising operands, back to back
    push_op({112'hAAAA, 16'h1357}, {112'h0, 16'h7D00}, {112'h0, 16'h3C00}, 3'd2, 0, 1, 0, 1,
            0, 0, 2'b00, 2'b00, 1'b0, 16'h0, 5'h0, "R10 zero masked sNaN");
    push_op({112'hBBBB, 16'h1357}, {112'h0, 16'h7BFF}, {112'h0, 16'h4000}, 3'd2, 0, 1, 0, 0,
            0, 0, 2'b00, 2'b00, 1'b0, 16'h0, 5'h0, "R10 merge masked overflow");
    push_op({112'hCCCC, 16'h0000}, {112'h0, 16'h0001}, {112'h0, 16'h3800}, 3'd2, 0, 1, 1, 1,
            0, 0, 2'b00, 2'b00, 1'b0, 16'h0, 5'h0, "R10 mask bit set");
    push_op({112'hDDDD, 16'h0000}, {112'h0, 16'h0001}, {112'h0, 16'h3800}, 3'd2, 0, 1, 0, 0,
            0, 0, 2'b00, 2'b00, 1'b0, 16'h0, 5'h0, "R10 merge masked tiny");
    // R11: upper lanes
    push_op({112'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 16'h4000}, {128{1'b1}}, {128{1'b1}},
            3'd2, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00, 1'b0, 16'h0, 5'h0, "R11 upper pass");
    idle(4);
    held = result;
    @(negedge clk);
    dst_vec = ~dst_vec; src2_vec = 128'h55; in_valid = 1'b0;
    idle(2);
    n_cmp++;
    if (out_valid !== 1'b0 || result !== held) begin
      n_bad++;
      $display("FAIL R12 hold while idle: actual v=%b r=%h expected v=0 r=%h", out_valid, result, held);
    end

    // R4: random mixed stream through the reference model
    for (int i = 0; i < 600; i++) begin
      logic [127:0] d, s2, s3;
      d  = {32'($urandom), 32'($urandom), 32'($urandom), 16'($urandom), rnd_half()};
      s2 = {112'($urandom), rnd_half()};
      s3 = {112'($urandom), rnd_half()};
      push_op(d, s2, s3, 3'($urandom_range(3)), 1'($urandom), 1'($urandom_range(3) == 0),
              1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
              2'($urandom), 1'b0, 16'h0, 5'h0, "R4 random");
      if ($urandom_range(7) == 0) idle(1);
    end
    idle(4);
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R12 missing outputs: actual %0d pending expected 0", exp_q.size());
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule